// File: doc/BRIEF.md
# Mesh Compare-Exchange Sorting Array

The block holds N = n x n keys in a square grid of cells, one key per cell. A cell can swap its key only with the cell directly left, right, above or below it. The grid has no wraparound links, so edge cells have two or three partners. A sequencer runs phases of odd-even transposition across the whole grid. Each phase works either along rows or along columns, and every cell pair of that phase acts in the same step.

Rows and columns are sorted alternately, in the manner of shearsort, until the grid is in snake order. A horizontal step costs one route cycle, one compare cycle and one return cycle. A vertical step models the longer path with two route cycles, one compare cycle and two return cycles.

Software loads all keys in parallel while the block is idle and pulses start. When done rises, it reads the sorted keys in parallel. The readout is already arranged in snake index order.

Top module: `mesh_sort_array`

## Requirements
- R1: After reset every cell holds 0, and busy_o and done_o are low.
- R2: A cycle with load_i high while idle writes keys_i into the grid and clears done_o. The key for cell (row r, column c) is taken from keys_i slot r*n+c, where slot s is bits [s*KEY_W +: KEY_W].
- R3: keys_o slot k always shows the key at snake index k. That index is row r = k/n. In even rows the column is k%n; in odd rows it is n-1-k%n.
- R4: A cycle with start_i high, load_i low and the block idle starts a sort. busy_o is high from the next cycle until the sort completes.
- R5: A horizontal step takes 3 cycles: route, compare, return. Keys change only at the clock edge that ends the return cycle.
- R6: A vertical step takes 5 cycles: 2 route, 1 compare, 2 return. Keys change only at the edge that ends the last return cycle.
- R7: A row phase is n steps. Even steps pair columns (0,1),(2,3),...; odd steps pair (1,2),(3,4),... Even rows end each pair ascending left to right, odd rows descending. Equal keys stay in place.
- R8: A column phase is n steps with the same pairing on row indices. Each pair ends with the smaller key in the upper cell.
- R9: Phases alternate row, column, row, and so on, with ceil(log2 n)+1 row phases in total, ending on a row phase. For n=4 a sort takes 76 cycles from the start edge to done.
- R10: At completion busy_o falls and done_o rises on the same edge. done_o then stays high until the next accepted load or start. keys_o is then non-decreasing and holds the loaded keys in a new order.
- R11: load_i and start_i have no effect while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Parallel key load, honoured when idle |
| keys_i | input | N*KEY_W | Keys to load, row-major grid order |
| start_i | input | 1 | Start pulse, honoured when idle and not loading |
| busy_o | output | 1 | Sort in progress |
| done_o | output | 1 | Last sort complete, grid in snake order |
| keys_o | output | N*KEY_W | Grid keys in snake index order |

## Verification
Corrupted key state shows on keys_o at the first edge after it occurs, because the readout is unregistered. A wrong pairing or a wrong direction flag shows as a wrong key at the end of the step's return cycle, that is 3 or 5 cycles after the step starts. A sequencer that loses count of sub-cycles, steps or phases shifts every later commit in time. The per-cycle reference therefore flags it at the first commit that is early or late, and also flags done_o rising in the wrong cycle.

// File: rtl/mesh_sort_pkg.sv
package mesh_sort_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROUTE,
    ST_CMP,
    ST_RET
  } seq_state_e;

  function automatic int snake_col(int row, int j, int n_side);
    return (row % 2 == 0) ? j : (n_side - 1 - j);
  endfunction
endpackage

// File: rtl/mesh_sort_seq.sv
module mesh_sort_seq
  import mesh_sort_pkg::*;
#(
  parameter int N_SIDE  = 4,
  parameter int ROUTE_H = 1,
  parameter int ROUTE_V = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic load_i,
  output logic busy_o,
  output logic done_o,
  output logic vert_o,
  output logic odd_o,
  output logic route_o,
  output logic cmp_o,
  output logic commit_o
);
  localparam int ROW_PHASES = $clog2(N_SIDE) + 1;
  localparam int LAST_PHASE = 2 * ROW_PHASES - 2;
  localparam int PH_W       = $clog2(LAST_PHASE + 1);
  localparam int STEP_W     = $clog2(N_SIDE);
  localparam int ROUTE_MAX  = (ROUTE_H > ROUTE_V) ? ROUTE_H : ROUTE_V;
  localparam int SUB_W      = $clog2(ROUTE_MAX + 1);

  seq_state_e        state_q, state_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic              done_q, done_d;
  logic              vert, sub_last, step_last, phase_last, go, commit, finish;

  assign vert       = phase_q[0];
  assign sub_last   = sub_q == (vert ? SUB_W'(ROUTE_V - 1) : SUB_W'(ROUTE_H - 1));
  assign step_last  = step_q == STEP_W'(N_SIDE - 1);
  assign phase_last = phase_q == PH_W'(LAST_PHASE);
  assign go         = (state_q == ST_IDLE) && start_i && !load_i;
  assign commit     = (state_q == ST_RET) && sub_last;
  assign finish     = commit && step_last && phase_last;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    step_d  = step_q;
    sub_d   = sub_q;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_ROUTE;
          phase_d = '0;
          step_d  = '0;
          sub_d   = '0;
        end
      end
      ST_ROUTE: begin
        if (sub_last) begin
          state_d = ST_CMP;
          sub_d   = '0;
        end else begin
          sub_d = sub_q + SUB_W'(1);
        end
      end
      ST_CMP: begin
        state_d = ST_RET;
        sub_d   = '0;
      end
      ST_RET: begin
        if (!sub_last) begin
          sub_d = sub_q + SUB_W'(1);
        end else begin
          sub_d = '0;
          if (!step_last) begin
            step_d  = step_q + STEP_W'(1);
            state_d = ST_ROUTE;
          end else if (phase_last) begin
            state_d = ST_IDLE;
          end else begin
            phase_d = phase_q + PH_W'(1);
            step_d  = '0;
            state_d = ST_ROUTE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    done_d = done_q;
    if (finish) done_d = 1'b1;
    else if ((state_q == ST_IDLE) && (load_i || start_i)) done_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      step_q  <= '0;
      sub_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      step_q  <= step_d;
      sub_q   <= sub_d;
      done_q  <= done_d;
    end
  end

  assign busy_o   = state_q != ST_IDLE;
  assign done_o   = done_q;
  assign vert_o   = vert;
  assign odd_o    = step_q[0];
  assign route_o  = state_q == ST_ROUTE;
  assign cmp_o    = state_q == ST_CMP;
  assign commit_o = commit;

  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE)); // R10

  AST_END_ON_ROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> !$past(vert)); // R9

  if (ROUTE_H == 1) begin : g_h_len
    AST_H_STEP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit && !vert) |-> ($past(state_q) == ST_CMP)); // R5
  end

  if (ROUTE_V == 2) begin : g_v_len
    AST_V_STEP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit && vert) |-> ($past(state_q) == ST_RET && $past(state_q, 2) == ST_CMP)); // R6
  end
endmodule

// File: rtl/mesh_sort_cell.sv
module mesh_sort_cell #(
  parameter int KEY_W  = 8,
  parameter int N_SIDE = 4,
  parameter int ROW    = 0,
  parameter int COL    = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [KEY_W-1:0] load_key_i,
  input  logic [KEY_W-1:0] left_i,
  input  logic [KEY_W-1:0] right_i,
  input  logic [KEY_W-1:0] up_i,
  input  logic [KEY_W-1:0] down_i,
  input  logic             vert_i,
  input  logic             odd_i,
  input  logic             route_i,
  input  logic             cmp_i,
  input  logic             commit_i,
  output logic [KEY_W-1:0] key_o
);
  localparam logic ROW_ODD = (ROW % 2) == 1;
  localparam logic COL_ODD = (COL % 2) == 1;
  localparam logic H_LO_OK = COL < N_SIDE - 1;
  localparam logic H_HI_OK = COL > 0;
  localparam logic V_LO_OK = ROW < N_SIDE - 1;
  localparam logic V_HI_OK = ROW > 0;

  logic [KEY_W-1:0] key_q, nbr_q, partner;
  logic             swap_q, is_low, active, desc, take;

  // low member of a pair sits at the even/odd position chosen by the step
  assign is_low  = (vert_i ? ROW_ODD : COL_ODD) == odd_i;
  assign active  = vert_i ? (is_low ? V_LO_OK : V_HI_OK) : (is_low ? H_LO_OK : H_HI_OK);
  assign partner = vert_i ? (is_low ? down_i : up_i) : (is_low ? right_i : left_i);
  assign desc    = !vert_i && ROW_ODD;
  assign take    = (is_low ^ desc) ? (nbr_q < key_q) : (nbr_q > key_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q  <= '0;
      nbr_q  <= '0;
      swap_q <= 1'b0;
    end else begin
      if (route_i) nbr_q <= partner;
      if (cmp_i) swap_q <= active && take;
      if (load_i) key_q <= load_key_i;
      else if (commit_i && swap_q) key_q <= nbr_q;
    end
  end

  assign key_o = key_q;

  AST_KEY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !commit_i) |=> $stable(key_q)); // R11
endmodule

// File: rtl/mesh_sort_snake_map.sv
module mesh_sort_snake_map
  import mesh_sort_pkg::*;
#(
  parameter int KEY_W  = 8,
  parameter int N_SIDE = 4
) (
  input  logic [N_SIDE*N_SIDE*KEY_W-1:0] grid_i,
  output logic [N_SIDE*N_SIDE*KEY_W-1:0] snake_o
);
  for (genvar k = 0; k < N_SIDE * N_SIDE; k++) begin : g_slot
    localparam int R   = k / N_SIDE;
    localparam int C   = snake_col(R, k % N_SIDE, N_SIDE);
    localparam int SRC = R * N_SIDE + C;
    assign snake_o[k*KEY_W +: KEY_W] = grid_i[SRC*KEY_W +: KEY_W];
  end
endmodule

// File: rtl/mesh_sort_array.sv
module mesh_sort_array #(
  parameter int N_SIDE  = 4,
  parameter int KEY_W   = 8,
  parameter int ROUTE_H = 1,
  parameter int ROUTE_V = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          load_i,
  input  logic [N_SIDE*N_SIDE*KEY_W-1:0] keys_i,
  input  logic                          start_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [N_SIDE*N_SIDE*KEY_W-1:0] keys_o
);
  localparam int N_CELLS = N_SIDE * N_SIDE;

  logic             busy, vert, odd, route, cmp, commit, load_en;
  logic [KEY_W-1:0] cell_key [N_CELLS];
  logic [N_CELLS*KEY_W-1:0] grid_flat;

  mesh_sort_seq #(
    .N_SIDE (N_SIDE),
    .ROUTE_H(ROUTE_H),
    .ROUTE_V(ROUTE_V)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_i  (load_i),
    .busy_o  (busy),
    .done_o  (done_o),
    .vert_o  (vert),
    .odd_o   (odd),
    .route_o (route),
    .cmp_o   (cmp),
    .commit_o(commit)
  );

  assign load_en = load_i && !busy;

  for (genvar r = 0; r < N_SIDE; r++) begin : g_row
    for (genvar c = 0; c < N_SIDE; c++) begin : g_col
      localparam int IDX = r * N_SIDE + c;
      logic [KEY_W-1:0] left_w, right_w, up_w, down_w;

      if (c > 0) begin : g_l
        assign left_w = cell_key[IDX-1];
      end else begin : g_nl
        assign left_w = '0;
      end
      if (c < N_SIDE - 1) begin : g_r
        assign right_w = cell_key[IDX+1];
      end else begin : g_nr
        assign right_w = '0;
      end
      if (r > 0) begin : g_u
        assign up_w = cell_key[IDX-N_SIDE];
      end else begin : g_nu
        assign up_w = '0;
      end
      if (r < N_SIDE - 1) begin : g_d
        assign down_w = cell_key[IDX+N_SIDE];
      end else begin : g_nd
        assign down_w = '0;
      end

      mesh_sort_cell #(
        .KEY_W (KEY_W),
        .N_SIDE(N_SIDE),
        .ROW   (r),
        .COL   (c)
      ) u_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (load_en),
        .load_key_i(keys_i[IDX*KEY_W +: KEY_W]),
        .left_i    (left_w),
        .right_i   (right_w),
        .up_i      (up_w),
        .down_i    (down_w),
        .vert_i    (vert),
        .odd_i     (odd),
        .route_i   (route),
        .cmp_i     (cmp),
        .commit_i  (commit),
        .key_o     (cell_key[IDX])
      );

      assign grid_flat[IDX*KEY_W +: KEY_W] = cell_key[IDX];
    end
  end

  mesh_sort_snake_map #(
    .KEY_W (KEY_W),
    .N_SIDE(N_SIDE)
  ) u_map (
    .grid_i (grid_flat),
    .snake_o(keys_o)
  );

  assign busy_o = busy;

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !load_i && !busy_o) |=> busy_o); // R4

  AST_LOAD_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o) |=> !done_o); // R2
endmodule

// File: tb/mesh_sort_array_tb.sv
`timescale 1ns/1ps
module mesh_sort_array_tb;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int NC = N * N;
  localparam int COST_H = 3;
  localparam int COST_V = 5;
  localparam int ROW_PH = $clog2(N) + 1;
  localparam int LAST_PH = 2 * ROW_PH - 2;
  localparam int SORT_CYC = ROW_PH * N * COST_H + (ROW_PH - 1) * N * COST_V;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0;
  logic start_i = 1'b0;
  logic [NC*W-1:0] keys_in = '0;
  logic busy_o, done_o;
  logic [NC*W-1:0] keys_o;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;

  int m_grid [N][N];
  bit m_busy, m_done;
  int m_phase, m_step, m_left;

  always #5 clk = ~clk;

  mesh_sort_array #(.N_SIDE(N), .KEY_W(W)) u_dut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .load_i (load_i),
    .keys_i (keys_in),
    .start_i(start_i),
    .busy_o (busy_o),
    .done_o (done_o),
    .keys_o (keys_o)
  );

  function automatic int cost(int ph);
    return (ph % 2 == 1) ? COST_V : COST_H;
  endfunction

  task automatic model_step(int ph, int st);
    int t;
    if (ph % 2 == 0) begin
      for (int r = 0; r < N; r++)
        for (int c = st % 2; c + 1 < N; c += 2)
          if ((r % 2 == 0) ? (m_grid[r][c] > m_grid[r][c+1]) : (m_grid[r][c] < m_grid[r][c+1])) begin
            t = m_grid[r][c]; m_grid[r][c] = m_grid[r][c+1]; m_grid[r][c+1] = t;
          end
    end else begin
      for (int c = 0; c < N; c++)
        for (int r = st % 2; r + 1 < N; r += 2)
          if (m_grid[r][c] > m_grid[r+1][c]) begin
            t = m_grid[r][c]; m_grid[r][c] = m_grid[r+1][c]; m_grid[r+1][c] = t;
          end
    end
  endtask

  // behavioural reference, advanced on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) m_grid[r][c] = 0;
      m_busy = 0; m_done = 0; m_phase = 0; m_step = 0; m_left = 0;
    end else if (!m_busy) begin
      if (load_i) begin
        for (int r = 0; r < N; r++)
          for (int c = 0; c < N; c++) m_grid[r][c] = int'(keys_in[(r*N+c)*W +: W]);
        m_done = 0;
      end else if (start_i) begin
        m_busy = 1; m_done = 0; m_phase = 0; m_step = 0; m_left = cost(0);
      end
    end else begin
      m_left--;
      if (m_left == 0) begin
        model_step(m_phase, m_step);
        if (m_step == N - 1) begin
          if (m_phase == LAST_PH) begin
            m_busy = 0; m_done = 1;
          end else begin
            m_phase++; m_step = 0;
          end
        end else m_step++;
        m_left = cost(m_phase);
      end
    end
  end

  function automatic logic [NC*W-1:0] model_snake();
    logic [NC*W-1:0] v;
    for (int k = 0; k < NC; k++) begin
      int r, c;
      r = k / N;
      c = (r % 2 == 0) ? (k % N) : (N - 1 - k % N);
      v[k*W +: W] = W'(m_grid[r][c]);
    end
    return v;
  endfunction

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_en) begin
      logic [NC*W-1:0] e;
      int bad;
      e = model_snake();
      bad = -1;
      for (int k = NC - 1; k >= 0; k--) if (keys_o[k*W +: W] !== e[k*W +: W]) bad = k;
      if (bad < 0) check(1'b1, "", 0, 0);
      else check(1'b0, $sformatf("R3/R5/R6/R7/R8 keys_o slot %0d", bad),
                 int'(keys_o[bad*W +: W]), int'(e[bad*W +: W]));
      check(busy_o === m_busy, "R4/R11 busy_o", int'(busy_o), int'(m_busy));
      check(done_o === m_done, "R10 done_o", int'(done_o), int'(m_done));
    end
  end

  task automatic run_sort(int pat, bit inject);
    int q[$];
    int cnt;
    @(negedge clk);
    for (int i = 0; i < NC; i++) begin
      int v;
      case (pat)
        0: v = $urandom_range(255);
        1: v = 250 - i * 13;
        2: v = 77;
        3: v = $urandom_range(2);
        default: v = i * 9;
      endcase
      keys_in[i*W +: W] = W'(v);
      q.push_back(v);
    end
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    check(done_o === 1'b0, "R2 done cleared by load", int'(done_o), 0);
    check(keys_o[W-1:0] === keys_in[W-1:0], "R2/R3 slot0 after load", int'(keys_o[W-1:0]), int'(keys_in[W-1:0]));
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R4 busy after start", int'(busy_o), 1);
    cnt = 0;
    while (!done_o && cnt < 1000) begin
      @(negedge clk);
      cnt++;
      if (inject && cnt == 10) begin
        keys_in = '1;
        load_i = 1'b1;
        start_i = 1'b1;
      end else begin
        load_i = 1'b0;
        start_i = 1'b0;
      end
    end
    load_i = 1'b0;
    start_i = 1'b0;
    check(cnt == SORT_CYC, "R9 sort length", cnt, SORT_CYC);
    check(busy_o === 1'b0, "R10 busy low at done", int'(busy_o), 0);
    for (int k = 1; k < NC; k++)
      check(keys_o[k*W +: W] >= keys_o[(k-1)*W +: W], $sformatf("R10 snake order slot %0d", k),
            int'(keys_o[k*W +: W]), int'(keys_o[(k-1)*W +: W]));
    q.sort();
    for (int k = 0; k < NC; k++)
      check(int'(keys_o[k*W +: W]) == q[k], $sformatf("R10 permutation slot %0d", k),
            int'(keys_o[k*W +: W]), q[k]);
    repeat (3) @(negedge clk);
    check(done_o === 1'b1, "R10 done held", int'(done_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R10 watchdog expired act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(keys_o === '0, "R1 keys after reset", int'(keys_o[W-1:0]), 0);
    check(busy_o === 1'b0, "R1 busy after reset", int'(busy_o), 0);
    check(done_o === 1'b0, "R1 done after reset", int'(done_o), 0);
    mon_en = 1'b1;
    run_sort(0, 1'b0);
    run_sort(1, 1'b0);
    run_sort(2, 1'b0);
    run_sort(3, 1'b0);
    run_sort(0, 1'b1);
    run_sort(4, 1'b0);
    run_sort(0, 1'b0);
    repeat (2) @(negedge clk);
    mon_en = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule